// File: doc/BRIEF.md
# Legacy System Control Port Decoder

This block sits on a byte-wide I/O bus and answers a small set of system control addresses. One special port (0x92) combines a soft-reset request with an endian-mode select. A window of ports in the 0x800 range holds identification bytes that never change, a few live control registers, and two addresses whose writes only produce a one-cycle strobe toward an external non-volatile memory lock.

The bus has an address, read and write strobes, write data and registered read data. A write takes effect on the clock edge that samples it. Read data appears one clock after the read strobe and holds until the next read. The live state drives level outputs: soft reset, little-endian mode, disk activity light and I/O-map type. Any address the block does not decode reads as all ones, and a write to it does nothing.

Top module: `sysport_ctrl`

## Requirements
- R1: After a synchronous reset, soft_reset_o, little_endian_o, disk_led_o, map_contig_o, lock_pulse_o, lock_id_o and io_rdata are all zero. The stored system control value is also zero.
- R2: A write to 0x0092 sets soft_reset_o to data bit 0 and little_endian_o to data bit 1 from the next clock.
- R3: A read of 0x0092 returns little_endian_o in bit 1 and zero in all other bits.
- R4: Reads of the identification ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03.
- R5: Writes to 0x0800, 0x0802 and 0x0803 change no output, and the same ports still read back their fixed bytes.
- R6: A write to 0x0808 sets disk_led_o to data bit 0.
- R7: A write to 0x0810 raises lock_pulse_o for exactly one cycle with lock_id_o = 1. A write to 0x0812 does the same with lock_id_o = 2. The write data has no effect. When lock_pulse_o is low, lock_id_o is 0.
- R8: A write to 0x081C stores data bits 3:0. A read of 0x081C returns them in bits 3:0, with bits 7:4 zero.
- R9: A write to 0x0850 sets map_contig_o to data bit 0. A read of 0x0850 returns that flag in bit 0, with the other bits zero.
- R10: A read of any other address returns 0xFF. This includes 0x0814, 0x0808, 0x0812 and addresses that match a decoded port only in the low bits. A write to any such address changes no output and no stored value.
- R11: io_rdata is updated only on a clock that samples io_rd high, so it is valid one clock after the read strobe and holds while io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W (16) | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | DATA_W (8) | Write data |
| io_rdata | output | DATA_W (8) | Registered read data |
| soft_reset_o | output | 1 | Soft-reset request level |
| little_endian_o | output | 1 | Little-endian mode flag |
| disk_led_o | output | 1 | Disk activity light |
| map_contig_o | output | 1 | Contiguous I/O-map type level |
| lock_pulse_o | output | 1 | One-cycle lock-toggle strobe |
| lock_id_o | output | 2 | Lock number for the strobe (1 or 2) |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data and a 4-bit system control field. With the full 16-bit address, the bench can probe aliases such as 0x1092 and 0x0892, which agree with decoded ports in the low byte or low nibbles. This shows that the whole address takes part in the decode. The 4-bit control field makes the masking of written bits 7:4 visible on readback.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

  // Port addresses (the decode depends on these exact values)
  localparam int unsigned A_SPECIAL = 'h0092;
  localparam int unsigned A_CPUCFG  = 'h0800;
  localparam int unsigned A_FEAT    = 'h0802;
  localparam int unsigned A_STAT    = 'h0803;
  localparam int unsigned A_LED     = 'h0808;
  localparam int unsigned A_EQUIP   = 'h080C;
  localparam int unsigned A_XFEAT   = 'h0810;
  localparam int unsigned A_LOCK2   = 'h0812;
  localparam int unsigned A_KEY     = 'h0818;
  localparam int unsigned A_SYSCTL  = 'h081C;
  localparam int unsigned A_CACHE   = 'h0823;
  localparam int unsigned A_MAPT    = 'h0850;

  // Fixed identification bytes
  localparam logic [7:0] V_CPUCFG = 8'hEF;
  localparam logic [7:0] V_FEAT   = 8'hAD;
  localparam logic [7:0] V_STAT   = 8'hE0;
  localparam logic [7:0] V_EQUIP  = 8'h3C;
  localparam logic [7:0] V_XFEAT  = 8'h39;
  localparam logic [7:0] V_KEY    = 8'h00;
  localparam logic [7:0] V_CACHE  = 8'h03;
  localparam logic [7:0] V_MISS   = 8'hFF;

  typedef struct packed {
    logic special;
    logic cpucfg;
    logic feat;
    logic stat;
    logic led;
    logic equip;
    logic xfeat;   // read: ext feature; write: lock 1 strobe
    logic lock2;
    logic key;
    logic sysctl;
    logic cache;
    logic mapt;
  } hit_t;

  // Special port readback: endian flag in bit 1
  function automatic logic [7:0] special_rd(input logic endian);
    special_rd = {6'b0, endian, 1'b0};
  endfunction

  // Zero-extend a narrow field into a byte
  function automatic logic [7:0] zext_nib(input logic [3:0] v);
    zext_nib = {4'b0, v};
  endfunction

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic              rd_hit,
  output logic              wr_hit
);

  function automatic logic match(input logic [ADDR_W-1:0] a, input int unsigned p);
    match = (a == ADDR_W'(p));
  endfunction

  always_comb begin
    hit.special = match(addr, A_SPECIAL);
    hit.cpucfg  = match(addr, A_CPUCFG);
    hit.feat    = match(addr, A_FEAT);
    hit.stat    = match(addr, A_STAT);
    hit.led     = match(addr, A_LED);
    hit.equip   = match(addr, A_EQUIP);
    hit.xfeat   = match(addr, A_XFEAT);
    hit.lock2   = match(addr, A_LOCK2);
    hit.key     = match(addr, A_KEY);
    hit.sysctl  = match(addr, A_SYSCTL);
    hit.cache   = match(addr, A_CACHE);
    hit.mapt    = match(addr, A_MAPT);
  end

  // Addresses with a defined read value
  assign rd_hit = hit.special | hit.cpucfg | hit.feat | hit.stat |
                  hit.equip | hit.xfeat | hit.key | hit.sysctl |
                  hit.cache | hit.mapt;

  // Addresses whose write has an effect
  assign wr_hit = hit.special | hit.led | hit.xfeat | hit.lock2 |
                  hit.sysctl | hit.mapt;

endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYSCTL_W  = 4,
  parameter int LOCK_ID_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  hit_t                 hit,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 soft_reset,
  output logic                 endian,
  output logic                 led,
  output logic [SYSCTL_W-1:0]  sysctl,
  output logic                 contig,
  output logic                 lock_pulse,
  output logic [LOCK_ID_W-1:0] lock_id
);

  localparam logic [LOCK_ID_W-1:0] ID_ONE = LOCK_ID_W'(1);
  localparam logic [LOCK_ID_W-1:0] ID_TWO = LOCK_ID_W'(2);

  logic wr_special, wr_led, wr_sysctl, wr_map, wr_lk1, wr_lk2;

  assign wr_special = wr & hit.special;
  assign wr_led     = wr & hit.led;
  assign wr_sysctl  = wr & hit.sysctl;
  assign wr_map     = wr & hit.mapt;
  assign wr_lk1     = wr & hit.xfeat;
  assign wr_lk2     = wr & hit.lock2;

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset <= 1'b0;
      endian     <= 1'b0;
    end else if (wr_special) begin
      soft_reset <= wdata[0];
      endian     <= wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         led <= 1'b0;
    else if (wr_led) led <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst)            sysctl <= '0;
    else if (wr_sysctl) sysctl <= wdata[SYSCTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         contig <= 1'b0;
    else if (wr_map) contig <= wdata[0];
  end

  // Lock strobe: one cycle per write, data ignored
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_pulse <= 1'b0;
      lock_id    <= '0;
    end else begin
      lock_pulse <= wr_lk1 | wr_lk2;
      lock_id    <= wr_lk1 ? ID_ONE : (wr_lk2 ? ID_TWO : '0);
    end
  end

endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux
  import sysport_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYSCTL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  hit_t                hit,
  input  logic                endian,
  input  logic [SYSCTL_W-1:0] sysctl,
  input  logic                contig,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = DATA_W'(V_MISS);
    unique case (1'b1)
      hit.special: rd_next = DATA_W'(special_rd(endian));
      hit.cpucfg:  rd_next = DATA_W'(V_CPUCFG);
      hit.feat:    rd_next = DATA_W'(V_FEAT);
      hit.stat:    rd_next = DATA_W'(V_STAT);
      hit.equip:   rd_next = DATA_W'(V_EQUIP);
      hit.xfeat:   rd_next = DATA_W'(V_XFEAT);
      hit.key:     rd_next = DATA_W'(V_KEY);
      hit.sysctl:  rd_next = DATA_W'(zext_nib(4'(sysctl)));
      hit.cache:   rd_next = DATA_W'(V_CACHE);
      hit.mapt:    rd_next = DATA_W'({7'b0, contig});
      default:     rd_next = DATA_W'(V_MISS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

endmodule

// File: rtl/sysport_ctrl.sv
module sysport_ctrl
  import sysport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SYSCTL_W  = 4,
  parameter int LOCK_ID_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [DATA_W-1:0]    io_rdata,
  output logic                 soft_reset_o,
  output logic                 little_endian_o,
  output logic                 disk_led_o,
  output logic                 map_contig_o,
  output logic                 lock_pulse_o,
  output logic [LOCK_ID_W-1:0] lock_id_o
);

  hit_t                hit;
  logic                rd_hit;
  logic                wr_hit;
  logic [SYSCTL_W-1:0] sysctl_q;

  sysport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (io_addr),
    .hit    (hit),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  sysport_regs #(
    .DATA_W(DATA_W), .SYSCTL_W(SYSCTL_W), .LOCK_ID_W(LOCK_ID_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (io_wr),
    .hit        (hit),
    .wdata      (io_wdata),
    .soft_reset (soft_reset_o),
    .endian     (little_endian_o),
    .led        (disk_led_o),
    .sysctl     (sysctl_q),
    .contig     (map_contig_o),
    .lock_pulse (lock_pulse_o),
    .lock_id    (lock_id_o)
  );

  sysport_rdmux #(.DATA_W(DATA_W), .SYSCTL_W(SYSCTL_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (io_rd),
    .hit    (hit),
    .endian (little_endian_o),
    .sysctl (sysctl_q),
    .contig (map_contig_o),
    .rdata  (io_rdata)
  );

endmodule

// File: rtl/sysport_ctrl_chk.sv
module sysport_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LOCK_ID_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    io_addr,
  input logic                 io_rd,
  input logic                 io_wr,
  input logic [DATA_W-1:0]    io_wdata,
  input logic [DATA_W-1:0]    io_rdata,
  input logic                 soft_reset_o,
  input logic                 little_endian_o,
  input logic                 disk_led_o,
  input logic                 map_contig_o,
  input logic                 lock_pulse_o,
  input logic [LOCK_ID_W-1:0] lock_id_o,
  input logic                 rd_hit,
  input logic                 wr_hit
);

  logic wr92, wr808, wr850, wrlk;
  assign wr92  = io_wr && io_addr == ADDR_W'('h0092);
  assign wr808 = io_wr && io_addr == ADDR_W'('h0808);
  assign wr850 = io_wr && io_addr == ADDR_W'('h0850);
  assign wrlk  = io_wr && (io_addr == ADDR_W'('h0810) || io_addr == ADDR_W'('h0812));

  p_special_wr_r2: assert property (@(posedge clk) disable iff (rst)
    wr92 |=> (soft_reset_o == $past(io_wdata[0]) && little_endian_o == $past(io_wdata[1])));

  p_special_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == ADDR_W'('h0092)) |=> io_rdata == DATA_W'({$past(little_endian_o), 1'b0}));

  p_cpucfg_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == ADDR_W'('h0800)) |=> io_rdata == DATA_W'(8'hEF));

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr92 |=> ($stable(soft_reset_o) && $stable(little_endian_o)));

  p_led_r6: assert property (@(posedge clk) disable iff (rst)
    wr808 |=> disk_led_o == $past(io_wdata[0]));

  p_lock_src_r7: assert property (@(posedge clk) disable iff (rst)
    lock_pulse_o |-> ($past(wrlk) && $countones(lock_id_o) == 1));

  p_lock_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_pulse_o |-> lock_id_o == '0);

  p_map_r9: assert property (@(posedge clk) disable iff (rst)
    wr850 |=> map_contig_o == $past(io_wdata[0]));

  p_miss_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !rd_hit) |=> io_rdata == {DATA_W{1'b1}});

  p_miss_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !wr_hit) |=> ($stable(disk_led_o) && $stable(map_contig_o) && !lock_pulse_o));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

bind sysport_ctrl sysport_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ID_W(LOCK_ID_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .io_addr         (io_addr),
  .io_rd           (io_rd),
  .io_wr           (io_wr),
  .io_wdata        (io_wdata),
  .io_rdata        (io_rdata),
  .soft_reset_o    (soft_reset_o),
  .little_endian_o (little_endian_o),
  .disk_led_o      (disk_led_o),
  .map_contig_o    (map_contig_o),
  .lock_pulse_o    (lock_pulse_o),
  .lock_id_o       (lock_id_o),
  .rd_hit          (rd_hit),
  .wr_hit          (wr_hit)
);

// File: tb/sysport_ctrl_bench.sv
module sysport_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        soft_reset_o, little_endian_o, disk_led_o, map_contig_o, lock_pulse_o;
  logic [1:0]  lock_id_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Bench-side model of the live state
  logic       m_rst, m_end, m_led, m_map;
  logic [3:0] m_ctl;

  always #5 clk = ~clk;

  sysport_ctrl u_sysport_ctrl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .soft_reset_o(soft_reset_o),
    .little_endian_o(little_endian_o), .disk_led_o(disk_led_o),
    .map_contig_o(map_contig_o), .lock_pulse_o(lock_pulse_o), .lock_id_o(lock_id_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    case (a)
      16'h0092: model_rd = {6'b0, m_end, 1'b0};
      16'h0800: model_rd = 8'hEF;
      16'h0802: model_rd = 8'hAD;
      16'h0803: model_rd = 8'hE0;
      16'h080C: model_rd = 8'h3C;
      16'h0810: model_rd = 8'h39;
      16'h0818: model_rd = 8'h00;
      16'h081C: model_rd = {4'b0, m_ctl};
      16'h0823: model_rd = 8'h03;
      16'h0850: model_rd = {7'b0, m_map};
      default:  model_rd = 8'hFF;
    endcase
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk(req, io_rdata, model_rd(a));
  endtask

  task automatic chk_levels(input string req);
    chk(req, {3'b0, soft_reset_o, little_endian_o, disk_led_o, map_contig_o, lock_pulse_o},
        {3'b0, m_rst, m_end, m_led, m_map, 1'b0});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_rst = 0; m_end = 0; m_led = 0; m_map = 0; m_ctl = 0;
  endtask

  task automatic t_reset();  // R1
    chk("R1 levels", {soft_reset_o, little_endian_o, disk_led_o, map_contig_o,
                      lock_pulse_o, lock_id_o, 1'b0}, 8'h00);
    chk("R1 rdata", io_rdata, 8'h00);
    rd_chk("R1 sysctl", 16'h081C);
  endtask

  task automatic t_special();  // R2 R3
    wr(16'h0092, 8'h01); m_rst = 1; m_end = 0; chk_levels("R2 bit0");
    rd_chk("R3 read", 16'h0092);
    wr(16'h0092, 8'hFE); m_rst = 0; m_end = 1; chk_levels("R2 bit1");
    rd_chk("R3 read", 16'h0092);
    wr(16'h0092, 8'h03); m_rst = 1; m_end = 1; chk_levels("R2 both");
    rd_chk("R3 read", 16'h0092);
    wr(16'h0092, 8'h00); m_rst = 0; m_end = 0; chk_levels("R2 clear");
  endtask

  task automatic t_ids();  // R4
    rd_chk("R4 0800", 16'h0800); rd_chk("R4 0802", 16'h0802);
    rd_chk("R4 0803", 16'h0803); rd_chk("R4 080C", 16'h080C);
    rd_chk("R4 0810", 16'h0810); rd_chk("R4 0818", 16'h0818);
    rd_chk("R4 0823", 16'h0823);
  endtask

  task automatic t_id_writes();  // R5
    wr(16'h0800, 8'hFF); wr(16'h0802, 8'h00); wr(16'h0803, 8'hFF);
    chk_levels("R5 levels");
    rd_chk("R5 0800", 16'h0800); rd_chk("R5 0802", 16'h0802);
    rd_chk("R5 0803", 16'h0803); rd_chk("R5 sysctl", 16'h081C);
  endtask

  task automatic t_led();  // R6
    wr(16'h0808, 8'h01); m_led = 1; chk_levels("R6 set");
    wr(16'h0808, 8'hFE); m_led = 0; chk_levels("R6 clear");
    wr(16'h0808, 8'h81); m_led = 1; chk_levels("R6 set again");
  endtask

  task automatic t_lock();  // R7
    @(negedge clk); io_addr = 16'h0810; io_wdata = 8'h00; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    chk("R7 pulse1", {5'b0, lock_pulse_o, lock_id_o}, 8'h05);
    @(negedge clk);
    chk("R7 pulse1 end", {5'b0, lock_pulse_o, lock_id_o}, 8'h00);
    @(negedge clk); io_addr = 16'h0812; io_wdata = 8'hFF; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    chk("R7 pulse2", {5'b0, lock_pulse_o, lock_id_o}, 8'h06);
    @(negedge clk);
    chk("R7 pulse2 end", {5'b0, lock_pulse_o, lock_id_o}, 8'h00);
    chk_levels("R7 levels");
  endtask

  task automatic t_sysctl();  // R8
    wr(16'h081C, 8'hA7); m_ctl = 4'h7; rd_chk("R8 low nibble", 16'h081C);
    wr(16'h081C, 8'hF5); m_ctl = 4'h5; rd_chk("R8 masked", 16'h081C);
    wr(16'h081C, 8'h0C); m_ctl = 4'hC; rd_chk("R8 value", 16'h081C);
  endtask

  task automatic t_map();  // R9
    wr(16'h0850, 8'h01); m_map = 1; chk_levels("R9 set");
    rd_chk("R9 read", 16'h0850);
    wr(16'h0850, 8'hFE); m_map = 0; chk_levels("R9 clear");
    rd_chk("R9 read", 16'h0850);
    wr(16'h0850, 8'h03); m_map = 1;
  endtask

  task automatic t_undecoded();  // R10
    logic [15:0] ra [8] = '{16'h0814, 16'h0808, 16'h0812, 16'h0801,
                            16'h0851, 16'h1092, 16'h0000, 16'h181C};
    foreach (ra[i]) rd_chk("R10 read miss", ra[i]);
    wr(16'h0814, 8'hFF); wr(16'h1850, 8'h00); wr(16'h0893, 8'h00);
    wr(16'h1808, 8'h00); wr(16'h181C, 8'h00);
    chk_levels("R10 write miss");
    rd_chk("R10 sysctl kept", 16'h081C);
    rd_chk("R10 map kept", 16'h0850);
  endtask

  task automatic t_latency();  // R11
    @(negedge clk); io_addr = 16'h0800; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; io_addr = 16'h0823;
    chk("R11 one clock", io_rdata, 8'hEF);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 hold", io_rdata, 8'hEF);
    end
    @(negedge clk); io_addr = 16'h0802; io_rd = 1'b1;
    @(negedge clk); chk("R11 b2b first", io_rdata, 8'hAD); io_addr = 16'h0803;
    @(negedge clk); chk("R11 b2b second", io_rdata, 8'hE0); io_rd = 1'b0;
  endtask

  task automatic t_reset_again();  // R1 mid-run
    wr(16'h0092, 8'h03); wr(16'h081C, 8'h0F); wr(16'h0808, 8'h01);
    do_reset();
    t_reset();
    chk_levels("R1 after use");
  endtask

  initial begin
    m_rst = 0; m_end = 0; m_led = 0; m_map = 0; m_ctl = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_special();
    t_ids();
    t_id_writes();
    t_led();
    t_lock();
    t_sysctl();
    t_map();
    t_undecoded();
    t_latency();
    t_reset_again();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule